// File: doc/BRIEF.md
# Configuration Access Router

This block sits between a configuration access port and the configuration register files of every function on a tree of buses. Those buses are joined by bus-to-bus bridges. Each access carries a 24-bit address made of a bus number, a device/function number and a register offset, plus a length and write data. The router decides which function, if any, the access belongs to. It then raises that function's select line for the cycle and passes the offset, length and write data straight through.

Bus 0 is the root segment. Each bridge owns one more segment, and the number of that segment is programmable. The router keeps one secondary bus number register per bridge. It fills that register by watching configuration writes aimed at the bridge's own function, and the write still reaches the bridge's register file. Functions are placed on segments by parameter. A function can ask for automatic placement, and it then takes the first free device number found by scanning upward in steps of one slot.

An access that matches no segment, or no function on the matched segment, still completes. A read returns all ones sized to the access width, and a write goes nowhere. Every access is acknowledged exactly one cycle after it is presented, and a new access may be presented every cycle.

Top module: `cfgr_router`

## Requirements
- R1: The address splits as bus = `req_addr[23:16]`, device/function = `req_addr[15:8]` (slot in bits [7:3], function in bits [2:0]) and offset = `req_addr[7:0]`. On a routed access, `tgt_offset`, `tgt_len` and `tgt_wdata` equal the request's offset, length and write data in the same cycle.
- R2: An access to bus 0 selects, combinationally in the same cycle, the single root-segment function whose device/function number equals the requested one exactly. `tgt_sel` is never more than one-hot.
- R3: An access to a nonzero bus goes to the segment of the bridge whose secondary bus number equals it. If two bridges hold the same number, the lowest-indexed bridge wins. The function is then chosen by an exact device/function match on that segment.
- R4: A write routed to a bridge's function updates that bridge's secondary bus number in two cases. At offset 0x19, of any length, the new value is `wdata[7:0]`. At offset 0x18 with a length of 2 or 4 bytes, the new value is `wdata[15:8]`. A 1-byte write at 0x18, a write at any other offset, and a write to a non-bridge function leave every secondary bus number unchanged.
- R5: A write that updates a secondary bus number is still forwarded to the bridge's function, with `tgt_sel` and `tgt_write` set.
- R6: A read that matches no function is acknowledged with `rsp_rdata` set by length. Length code 0 (1 byte) gives 0x000000FF. Code 1 (2 bytes) gives 0x0000FFFF. Codes 2 and 3 (4 bytes) give 0xFFFFFFFF.
- R7: A write that matches no function raises no `tgt_sel` bit, changes no secondary bus number and is still acknowledged.
- R8: A routed read returns on `rsp_rdata` the selected function's `tgt_rdata` slice as it stood in the request cycle.
- R9: `rsp_ack` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise. Back-to-back requests are each acknowledged. `rsp_rdata` is zero when `rsp_ack` is low and on write acknowledgements.
- R10: A function whose parameter device/function number is 0xFF is placed at the first number that is not already taken on its segment. The scan starts at `DEVFN_MIN` and steps by 8. Fixed functions claim their numbers first, then automatic ones claim theirs in index order. With the default map, function 3 lands at 0x18 on segment 1.
- R11: After reset, `rsp_ack` and `rsp_rdata` are 0 and every secondary bus number is 0, so every nonzero bus misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus, device/function, offset |
| req_len | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata | input | 32 | Write data |
| tgt_sel | output | NUM_FUNC | One-hot function select, combinational |
| tgt_write | output | 1 | Write strobe to the register files |
| tgt_offset | output | 8 | Register offset |
| tgt_len | output | 2 | Access length |
| tgt_wdata | output | 32 | Write data |
| tgt_rdata | input | NUM_FUNC*32 | Read data of every function, 32 bits each |
| rsp_ack | output | 1 | Completion, one cycle after the request |
| rsp_rdata | output | 32 | Read data of the completed access |

## Verification
The function select and the passed-through offset, length and data are combinational, so they are due in the same cycle as the request. The bench checks them a nanosecond after it drives the inputs. The acknowledgement, the read data and any secondary bus number update land on the next rising edge. The bench therefore holds each expected response for one cycle and compares it at the following falling edge, and it applies a bridge update in its model only to requests that come after the write. Every cycle, idle cycles included, gets a response comparison.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    typedef enum logic [1:0] {
        LEN_B1  = 2'd0,
        LEN_B2  = 2'd1,
        LEN_B4  = 2'd2,
        LEN_B4X = 2'd3
    } cfg_len_e;

    typedef struct packed {
        logic [7:0] bus;
        logic [7:0] devfn;
        logic [7:0] offset;
    } cfg_addr_t;

    typedef struct packed {
        logic        ack;
        logic [31:0] rdata;
    } rsp_state_t;

    localparam logic [7:0] SEC_BUS_OFS  = 8'h19;
    localparam logic [7:0] WIDE_BUS_OFS = 8'h18;

    // read data returned for an access that reaches no function
    function automatic logic [31:0] miss_fill(cfg_len_e len);
        case (len)
            LEN_B1:  return 32'h0000_00FF;
            LEN_B2:  return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgr_bus_match.sv
module cfgr_bus_match #(
    parameter int NUM_BRIDGE = 2,
    parameter int SEGW       = 2
) (
    input  logic [7:0]              bus,
    input  logic [NUM_BRIDGE*8-1:0] sec_bus,
    output logic                    seg_hit,
    output logic [SEGW-1:0]         seg_idx
);

    always_comb begin
        seg_hit = 1'b0;
        seg_idx = '0;
        if (bus == 8'h00) begin
            seg_hit = 1'b1;
        end else begin
            // walk from the top so the lowest bridge index is written last
            for (int k = NUM_BRIDGE - 1; k >= 0; k--) begin
                if (sec_bus[k*8 +: 8] == bus) begin
                    seg_hit = 1'b1;
                    seg_idx = SEGW'(k + 1);
                end
            end
        end
    end

endmodule

// File: rtl/cfgr_func_decode.sv
module cfgr_func_decode #(
    parameter int                    NUM_FUNC   = 6,
    parameter int                    SEGW       = 2,
    parameter logic [NUM_FUNC*4-1:0] FUNC_SEG   = '0,
    parameter logic [NUM_FUNC*8-1:0] FUNC_DEVFN = '0,
    parameter logic [7:0]            DEVFN_MIN  = 8'h00
) (
    input  logic                seg_hit,
    input  logic [SEGW-1:0]     seg_idx,
    input  logic [7:0]          devfn,
    output logic [NUM_FUNC-1:0] hit_vec
);

    localparam logic [7:0] AUTO_TAG = 8'hFF;

    // per function: bit 8 = placed, bits 7:0 = device/function number
    function automatic logic [NUM_FUNC*9-1:0] place_all();
        logic [NUM_FUNC*9-1:0] r;
        logic                  found;
        logic                  taken;
        r = '0;
        for (int i = 0; i < NUM_FUNC; i++) begin
            if (FUNC_DEVFN[i*8 +: 8] != AUTO_TAG)
                r[i*9 +: 9] = {1'b1, FUNC_DEVFN[i*8 +: 8]};
        end
        for (int i = 0; i < NUM_FUNC; i++) begin
            if (FUNC_DEVFN[i*8 +: 8] == AUTO_TAG) begin
                found = 1'b0;
                for (int d = int'(DEVFN_MIN); d < 256; d += 8) begin
                    if (!found) begin
                        taken = 1'b0;
                        for (int j = 0; j < NUM_FUNC; j++) begin
                            if (r[j*9 + 8] && FUNC_SEG[j*4 +: 4] == FUNC_SEG[i*4 +: 4]
                                && r[j*9 +: 8] == 8'(d))
                                taken = 1'b1;
                        end
                        if (!taken) begin
                            r[i*9 +: 9] = {1'b1, 8'(d)};
                            found = 1'b1;
                        end
                    end
                end
            end
        end
        return r;
    endfunction

    localparam logic [NUM_FUNC*9-1:0] PLACED = place_all();

    logic [NUM_FUNC-1:0] match;

    for (genvar i = 0; i < NUM_FUNC; i++) begin : g_fn
        assign match[i] = seg_hit && PLACED[i*9 + 8]
                       && (FUNC_SEG[i*4 +: 4] == 4'(seg_idx))
                       && (devfn == PLACED[i*9 +: 8]);
    end

    // keep the select one-hot even if a map places two functions alike
    always_comb begin
        hit_vec = '0;
        for (int i = NUM_FUNC - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_vec    = '0;
                hit_vec[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfgr_bridge_snoop.sv
module cfgr_bridge_snoop
    import cfgr_pkg::*;
#(
    parameter int                      NUM_BRIDGE  = 2,
    parameter int                      NUM_FUNC    = 6,
    parameter logic [NUM_BRIDGE*4-1:0] BRIDGE_FUNC = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_fire,
    input  logic [NUM_FUNC-1:0]     hit_vec,
    input  logic [7:0]              offset,
    input  cfg_len_e                len,
    input  logic [15:0]             wdata,
    output logic [NUM_BRIDGE*8-1:0] sec_bus
);

    typedef struct packed {
        logic [NUM_BRIDGE-1:0][7:0] sec;
    } snoop_state_t;

    snoop_state_t state_d, state_q;
    logic [NUM_BRIDGE-1:0] bridge_hit;

    for (genvar k = 0; k < NUM_BRIDGE; k++) begin : g_br
        localparam int FIDX = int'(BRIDGE_FUNC[k*4 +: 4]);
        assign bridge_hit[k] = hit_vec[FIDX];
        assign sec_bus[k*8 +: 8] = state_q.sec[k];
    end

    always_comb begin
        state_d = state_q;
        for (int k = 0; k < NUM_BRIDGE; k++) begin
            if (wr_fire && bridge_hit[k]) begin
                if (offset == SEC_BUS_OFS)
                    state_d.sec[k] = wdata[7:0];
                else if (offset == WIDE_BUS_OFS && len != LEN_B1)
                    state_d.sec[k] = wdata[15:8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    AST_SEC_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(sec_bus)); // R7
    AST_SEC_BYTE_LOW_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && offset == WIDE_BUS_OFS && len == LEN_B1) |=> $stable(sec_bus)); // R4
    AST_SEC_OTHER_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && offset != WIDE_BUS_OFS && offset != SEC_BUS_OFS) |=> $stable(sec_bus)); // R4

endmodule

// File: rtl/cfgr_router.sv
module cfgr_router
    import cfgr_pkg::*;
#(
    parameter int                      NUM_BRIDGE  = 2,
    parameter int                      NUM_FUNC    = 6,
    parameter logic [7:0]              DEVFN_MIN   = 8'h10,
    parameter logic [NUM_FUNC*4-1:0]   FUNC_SEG    = {4'd2, 4'd1, 4'd1, 4'd0, 4'd0, 4'd0},
    parameter logic [NUM_FUNC*8-1:0]   FUNC_DEVFN  = {8'h00, 8'h10, 8'hFF, 8'h09, 8'h08, 8'h00},
    parameter logic [NUM_BRIDGE*4-1:0] BRIDGE_FUNC = {4'd4, 4'd1}
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [23:0]            req_addr,
    input  logic [1:0]             req_len,
    input  logic [31:0]            req_wdata,
    output logic [NUM_FUNC-1:0]    tgt_sel,
    output logic                   tgt_write,
    output logic [7:0]             tgt_offset,
    output logic [1:0]             tgt_len,
    output logic [31:0]            tgt_wdata,
    input  logic [NUM_FUNC*32-1:0] tgt_rdata,
    output logic                   rsp_ack,
    output logic [31:0]            rsp_rdata
);

    localparam int SEGW = (NUM_BRIDGE + 1 > 1) ? $clog2(NUM_BRIDGE + 1) : 1;

    cfg_addr_t             addr;
    cfg_len_e              len;
    logic                  seg_hit;
    logic [SEGW-1:0]       seg_idx;
    logic [NUM_FUNC-1:0]   hit_vec;
    logic [NUM_BRIDGE*8-1:0] sec_bus;
    logic                  wr_fire;
    logic [31:0]           sel_rdata;
    rsp_state_t            state_d, state_q;

    assign addr = cfg_addr_t'(req_addr);
    assign len  = cfg_len_e'(req_len);

    cfgr_bus_match #(
        .NUM_BRIDGE (NUM_BRIDGE),
        .SEGW       (SEGW)
    ) u_bus_match (
        .bus     (addr.bus),
        .sec_bus (sec_bus),
        .seg_hit (seg_hit),
        .seg_idx (seg_idx)
    );

    cfgr_func_decode #(
        .NUM_FUNC   (NUM_FUNC),
        .SEGW       (SEGW),
        .FUNC_SEG   (FUNC_SEG),
        .FUNC_DEVFN (FUNC_DEVFN),
        .DEVFN_MIN  (DEVFN_MIN)
    ) u_func_decode (
        .seg_hit (seg_hit),
        .seg_idx (seg_idx),
        .devfn   (addr.devfn),
        .hit_vec (hit_vec)
    );

    assign wr_fire = req_valid && req_write && (|hit_vec);

    cfgr_bridge_snoop #(
        .NUM_BRIDGE  (NUM_BRIDGE),
        .NUM_FUNC    (NUM_FUNC),
        .BRIDGE_FUNC (BRIDGE_FUNC)
    ) u_snoop (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .hit_vec (hit_vec),
        .offset  (addr.offset),
        .len     (len),
        .wdata   (req_wdata[15:0]),
        .sec_bus (sec_bus)
    );

    // pass-through to the register files
    assign tgt_sel    = req_valid ? hit_vec : '0;
    assign tgt_write  = req_write;
    assign tgt_offset = addr.offset;
    assign tgt_len    = req_len;
    assign tgt_wdata  = req_wdata;

    always_comb begin
        sel_rdata = '0;
        for (int f = 0; f < NUM_FUNC; f++) begin
            if (hit_vec[f]) sel_rdata |= tgt_rdata[f*32 +: 32];
        end
    end

    always_comb begin
        state_d       = '0;
        state_d.ack   = req_valid;
        if (req_valid && !req_write)
            state_d.rdata = (|hit_vec) ? sel_rdata : miss_fill(len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_ack   = state_q.ack;
    assign rsp_rdata = state_q.rdata;

    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ack); // R9
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ack); // R9
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel)); // R2
    AST_SEL_NEEDS_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel != '0) |-> seg_hit); // R3
    AST_MISS_READ_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && tgt_sel == '0) |=> rsp_rdata[7:0] == 8'hFF); // R6
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ack |-> rsp_rdata == 32'h0); // R9

endmodule

// File: tb/cfgr_router_tb.sv
`timescale 1ns/1ps
module cfgr_router_tb;

    localparam int NF = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [23:0]       req_addr = '0;
    logic [1:0]        req_len = '0;
    logic [31:0]       req_wdata = '0;
    logic [NF-1:0]     tgt_sel;
    logic              tgt_write;
    logic [7:0]        tgt_offset;
    logic [1:0]        tgt_len;
    logic [31:0]       tgt_wdata;
    logic [NF*32-1:0]  tgt_rdata;
    logic              rsp_ack;
    logic [31:0]       rsp_rdata;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    int    sec_m [2];
    logic        exp_ack = 1'b0;
    logic [31:0] exp_rdata = '0;
    string       exp_tag = "R11";

    logic [7:0] mem [NF][256];

    always #2 clk = ~clk;

    cfgr_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .tgt_sel(tgt_sel), .tgt_write(tgt_write), .tgt_offset(tgt_offset),
        .tgt_len(tgt_len), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
        .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata)
    );

    function automatic int nbytes(logic [1:0] l);
        return (l == 2'd0) ? 1 : (l == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] mem_rd(int f, logic [7:0] ofs, logic [1:0] l);
        logic [31:0] v = '0;
        for (int k = 0; k < nbytes(l); k++) v[k*8 +: 8] = mem[f][8'(ofs + 8'(k))];
        return v;
    endfunction

    // behavioural register files behind the router
    always_comb begin
        for (int f = 0; f < NF; f++) tgt_rdata[f*32 +: 32] = mem_rd(f, tgt_offset, tgt_len);
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < NF; f++)
                for (int a = 0; a < 256; a++) mem[f][a] = 8'(f * 37 + a);
        end else begin
            for (int f = 0; f < NF; f++)
                if (tgt_sel[f] && tgt_write)
                    for (int k = 0; k < nbytes(tgt_len); k++)
                        mem[f][8'(tgt_offset + 8'(k))] = tgt_wdata[k*8 +: 8];
        end
    end

    // expected routing from the requirement text and the default map
    function automatic int route(logic [7:0] bus, logic [7:0] dfn);
        if (bus == 8'h00) begin
            if (dfn == 8'h00) return 0;
            if (dfn == 8'h08) return 1;
            if (dfn == 8'h09) return 2;
            return -1;
        end
        if (int'(bus) == sec_m[0]) begin
            if (dfn == 8'h10) return 4;
            if (dfn == 8'h18) return 3;   // automatically placed function (R10)
            return -1;
        end
        if (int'(bus) == sec_m[1]) return (dfn == 8'h00) ? 5 : -1;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic w, input logic [23:0] a,
                        input logic [1:0] l, input logic [31:0] d, input string tag);
        int          f;
        logic [NF-1:0] es;
        @(negedge clk);
        chk(rsp_ack === exp_ack, {exp_tag, " R9 ack"}, 32'(rsp_ack), 32'(exp_ack));
        chk(rsp_rdata === exp_rdata, {exp_tag, " rdata"}, rsp_rdata, exp_rdata);
        req_valid = v; req_write = w; req_addr = a; req_len = l; req_wdata = d;
        #1;
        f  = route(a[23:16], a[15:8]);
        es = (v && f >= 0) ? NF'(1) << f : '0;
        chk(tgt_sel === es, {tag, " select"}, 32'(tgt_sel), 32'(es));
        if (v && f >= 0) begin
            chk(tgt_offset === a[7:0] && tgt_len === l && tgt_wdata === d && tgt_write === w,
                "R1 pass-through", {tgt_len, 6'd0, tgt_offset, 16'd0}, {l, 6'd0, a[7:0], 16'd0});
        end
        exp_ack   = v;
        exp_tag   = tag;
        exp_rdata = '0;
        if (v && !w)
            exp_rdata = (f >= 0) ? mem_rd(f, a[7:0], l)
                      : (l == 2'd0) ? 32'h0000_00FF : (l == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        if (v && w && (f == 1 || f == 4)) begin
            int b = (f == 1) ? 0 : 1;
            if (a[7:0] == 8'h19) sec_m[b] = int'(d[7:0]);
            else if (a[7:0] == 8'h18 && l != 2'd0) sec_m[b] = int'(d[15:8]);
        end
    endtask

    function automatic logic [23:0] ad(logic [7:0] b, logic [7:0] dfn, logic [7:0] o);
        return {b, dfn, o};
    endfunction

    initial begin
        sec_m[0] = 0; sec_m[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step(0, 0, '0, 0, 0, "R11");
        step(1, 0, ad(8'h01, 8'h10, 8'h00), 2'd1, 0, "R11 unset bridge");
        step(1, 0, ad(8'h00, 8'h00, 8'h04), 2'd1, 0, "R2");
        step(1, 0, ad(8'h00, 8'h09, 8'h00), 2'd2, 0, "R2 multifunction");
        step(1, 0, ad(8'h00, 8'h01, 8'h00), 2'd0, 0, "R6 byte");
        step(1, 0, ad(8'h00, 8'h10, 8'h20), 2'd3, 0, "R6 word");
        step(1, 1, ad(8'h00, 8'h08, 8'h19), 2'd0, 32'h01, "R5 R4 snoop");
        step(1, 0, ad(8'h01, 8'h10, 8'h19), 2'd0, 0, "R3");
        step(1, 0, ad(8'h01, 8'h18, 8'h00), 2'd2, 0, "R10");
        step(1, 0, ad(8'h01, 8'h08, 8'h00), 2'd1, 0, "R6 empty slot");
        step(1, 1, ad(8'h01, 8'h10, 8'h18), 2'd2, 32'h0003_0201, "R4 wide");
        step(1, 0, ad(8'h02, 8'h00, 8'h00), 2'd2, 0, "R3 deep");
        step(1, 1, ad(8'h01, 8'h10, 8'h18), 2'd0, 32'h07, "R4 byte no update");
        step(1, 0, ad(8'h02, 8'h00, 8'h08), 2'd2, 0, "R4 held");
        step(1, 0, ad(8'h07, 8'h00, 8'h00), 2'd2, 0, "R4 held miss");
        step(1, 1, ad(8'h00, 8'h00, 8'h19), 2'd0, 32'h05, "R4 non-bridge");
        step(1, 0, ad(8'h05, 8'h00, 8'h00), 2'd0, 0, "R4 non-bridge miss");
        step(1, 1, ad(8'h00, 8'h01, 8'h19), 2'd0, 32'h09, "R7");
        step(1, 0, ad(8'h01, 8'h10, 8'h00), 2'd2, 0, "R7 no update");
        step(1, 0, ad(8'h09, 8'h00, 8'h00), 2'd2, 0, "R7 miss");
        step(1, 1, ad(8'h00, 8'h00, 8'h40), 2'd2, 32'hDEAD_BEEF, "R8 write");
        step(1, 0, ad(8'h00, 8'h00, 8'h40), 2'd2, 0, "R8");
        step(1, 0, ad(8'h00, 8'h00, 8'h42), 2'd1, 0, "R8 half");
        step(0, 0, '0, 0, 0, "R9 idle");
        step(0, 0, '0, 0, 0, "R9 idle");
        step(1, 1, ad(8'h01, 8'h10, 8'h19), 2'd1, 32'h0000_0001, "R3 duplicate");
        step(1, 0, ad(8'h01, 8'h10, 8'h04), 2'd2, 0, "R3 lowest wins");
        step(1, 0, ad(8'h02, 8'h00, 8'h00), 2'd2, 0, "R3 old bus gone");
        step(1, 0, ad(8'h01, 8'h00, 8'h00), 2'd2, 0, "R3 shadowed");
        step(0, 0, '0, 0, 0, "R9");
        step(0, 0, '0, 0, 0, "R9");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule